// File: doc/BRIEF.md
# Flash Command Sequencer with Write Buffer

This block models the command interface of a parallel NOR-style flash device as synthesizable logic. Each bus write cycle (`bus_we` high for one clock) carries a command code in the low data byte. The sequencer turns these cycles into read modes, single-word programs, buffered programs, block erases and block lock changes. Programs and erases are modelled as busy periods of fixed length. The array is a small register file in which programming can only clear bits and erasing sets a whole block back to all ones.

A buffered program is a strict sequence. It opens with E8h, then a count cycle whose address selects the target block and whose data gives `n`. Exactly `n+1` data cycles follow, each carrying a word offset and data, and then a D0h confirm. The operation starts only on that confirm. While the internal engine is busy, only bit 7 of the read bus is driven, and `rd_drive_mask` shows this. A failed or aborted sequence sets a sticky error flag in the status byte, and only a clear-status command removes it.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy` is 0, the read mode is array, `rd_drive_mask` is FFFFh and every array word reads FFFFh.
- R2: Both 40h and 10h open a single program. The next write ANDs its data into the addressed word, and `busy` is high for exactly PROG_LAT cycles.
- R3: The buffered program is E8h, then a count cycle, then n+1 data cycles, then D0h. `busy` is high for PROG_LAT+n+1 cycles, and afterwards each data word is ANDed into the word at {count-cycle block, data-cycle offset}.
- R4: The count limit is 1Fh in byte mode and 000Fh in word mode. Byte mode reads only the low data byte of the count cycle. A count above the limit sets the error bit and programs nothing. In byte mode, program data ANDs only into the low byte of a word.
- R5: Any code other than D0h in the confirm slot aborts the buffered program. The error bit is set, `busy` stays 0 and the array is unchanged.
- R6: `busy` never rises before the confirm cycle (for buffer and erase) or the data cycle (for single program). It stays 0 through all buffer data cycles.
- R7: While `busy` is high, `rd_drive_mask` is 0080h and `rd_data` is 0000h (bit 7 = ready = 0).
- R8: B0h during a program suspends it. `busy` drops, the status reads C0h and the word is not yet written. D0h resumes and completes the program. B0h during an erase is ignored.
- R9: With `prot_hi`=1, a program or erase aimed at a locked block fails. Status bits 4 and 1 are set, `busy` stays 0 and the array is unchanged. With `prot_hi`=0, the lock is bypassed.
- R10: The upper data byte of a command write is ignored (for example, 1270h acts as 70h).
- R11: 60h then 01h locks the addressed block. 60h then 2Fh locks it permanently. 60h then D0h clears every lock except the permanent ones.
- R12: The status byte is {ready, suspended, 0, error, 0, 0, lock-error, 0}. Error bits stay set across later successful operations until 50h clears them.
- R13: An undefined code in idle changes nothing. The read mode stays as it was and `busy` stays 0.
- R14: 20h then D0h erases the addressed block to FFFFh, with `busy` high for ERASE_LAT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write cycle, sampled at the rising clock edge |
| bus_addr | input | AW | Word address for writes and reads |
| bus_wdata | input | 16 | Write data; the low byte holds the command code |
| byte_mode | input | 1 | 1 selects byte-wide count and program data |
| prot_hi | input | 1 | 1 enforces block locks, 0 bypasses them |
| rd_data | output | 16 | Read bus: array word or status byte |
| rd_drive_mask | output | 16 | Bits of `rd_data` that are driven |
| busy | output | 1 | Internal engine running |

## Verification
The hardest state to reach is the confirm slot of a full-depth byte-mode buffer. It takes an E8h, a count of 1Fh and thirty-two data writes. The offsets wrap around a small block, so the expected contents come from ANDing every write that lands on each word. The bench builds this sequence in a loop, then drives the one-over-limit count and a wrong code at the confirm slot. Suspend is reached by issuing B0h on the cycle right after a single program's data write, while the busy window is still open.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PGM_SETUP, ST_BUF_COUNT, ST_BUF_DATA, ST_BUF_CONFIRM,
    ST_ERS_SETUP, ST_LOCK_SETUP, ST_BUSY, ST_SUSP
  } seq_state_t;

  typedef enum logic [1:0] {OP_NONE, OP_WORD, OP_BUF, OP_ERASE} op_kind_t;

  typedef enum logic [3:0] {
    C_READ_ARRAY, C_READ_STATUS, C_CLEAR_STATUS, C_PGM, C_BUF, C_ERASE,
    C_CONFIRM, C_SUSPEND, C_LOCK_SETUP, C_LOCK_ONE, C_LOCK_SEC, C_OTHER
  } cmd_t;

  // count argument as seen on the bus
  function automatic logic [15:0] count_arg(input logic [15:0] d, input logic bm);
    return bm ? {8'h00, d[7:0]} : d;
  endfunction

  // highest legal count argument
  function automatic logic [15:0] count_max(input logic bm, input int bufw);
    return bm ? 16'(2 * bufw - 1) : 16'(bufw - 1);
  endfunction

  // AND mask applied to an array word when programming
  function automatic logic [15:0] pgm_mask(input logic [15:0] d, input logic bm);
    return bm ? {8'hFF, d[7:0]} : d;
  endfunction

  // total busy cycles of an operation
  function automatic int unsigned busy_cycles(input op_kind_t k, input int unsigned n,
                                              input int unsigned plat, input int unsigned elat);
    case (k)
      OP_WORD:  return plat;
      OP_BUF:   return plat + n + 1;
      OP_ERASE: return elat;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/fcs_cmd_decode.sv
module fcs_cmd_decode
  import flash_seq_pkg::*;
(
  input  logic [7:0] code,
  output cmd_t       cmd
);
  always_comb begin
    case (code)
      8'hFF:        cmd = C_READ_ARRAY;
      8'h70:        cmd = C_READ_STATUS;
      8'h50:        cmd = C_CLEAR_STATUS;
      8'h40, 8'h10: cmd = C_PGM;
      8'hE8:        cmd = C_BUF;
      8'h20:        cmd = C_ERASE;
      8'hD0:        cmd = C_CONFIRM;
      8'hB0:        cmd = C_SUSPEND;
      8'h60:        cmd = C_LOCK_SETUP;
      8'h01:        cmd = C_LOCK_ONE;
      8'h2F:        cmd = C_LOCK_SEC;
      default:      cmd = C_OTHER;
    endcase
  end
endmodule

// File: rtl/fcs_wbuf.sv
module fcs_wbuf #(
  parameter int DEPTH = 32,
  parameter int OFFW  = 3,
  localparam int IW   = $clog2(DEPTH),
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            push,
  input  logic [OFFW-1:0] push_off,
  input  logic [15:0]     push_data,
  input  logic [IW-1:0]   rd_idx,
  output logic [OFFW-1:0] rd_off,
  output logic [15:0]     rd_data,
  output logic [FW-1:0]   fill
);
  logic [OFFW-1:0] off_q  [DEPTH];
  logic [15:0]     data_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      fill <= '0;
    end else if (push && fill < FW'(DEPTH)) begin
      off_q[fill[IW-1:0]]  <= push_off;
      data_q[fill[IW-1:0]] <= push_data;
      fill <= fill + 1'b1;
    end
  end

  assign rd_off  = off_q[rd_idx];
  assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
  parameter int NB   = 4,
  parameter int WPB  = 8,
  localparam int OFFW = $clog2(WPB),
  localparam int BW   = $clog2(NB),
  localparam int AW   = BW + OFFW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_mask,
  input  logic          erase_en,
  input  logic [BW-1:0] erase_blk,
  input  logic          lock_set,
  input  logic          lock_sec,
  input  logic [BW-1:0] lock_blk,
  input  logic          lock_clr,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_word,
  output logic [NB-1:0] locked
);
  logic [15:0] mem [NB*WPB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB*WPB; i++) mem[i] <= 16'hFFFF;
    end else begin
      if (erase_en)
        for (int w = 0; w < WPB; w++) mem[int'(erase_blk)*WPB + w] <= 16'hFFFF;
      if (wr_en)
        mem[wr_addr] <= mem[wr_addr] & wr_mask;
    end
  end

  assign rd_word = mem[rd_addr];

  for (genvar b = 0; b < NB; b++) begin : g_blk
    logic lk, sk;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lk <= 1'b0;
        sk <= 1'b0;
      end else if (lock_set && lock_blk == BW'(b)) begin
        lk <= 1'b1;
        if (lock_sec) sk <= 1'b1;
      end else if (lock_clr && !sk) begin
        lk <= 1'b0;
      end
    end
    assign locked[b] = lk;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int WORDS_PER_BLOCK = 8,
  parameter int BUF_WORDS       = 16,
  parameter int PROG_LAT        = 4,
  parameter int ERASE_LAT       = 8,
  localparam int AW = $clog2(NUM_BLOCKS) + $clog2(WORDS_PER_BLOCK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  input  logic          byte_mode,
  input  logic          prot_hi,
  output logic [15:0]   rd_data,
  output logic [15:0]   rd_drive_mask,
  output logic          busy
);
  localparam int OFFW  = $clog2(WORDS_PER_BLOCK);
  localparam int BW    = $clog2(NUM_BLOCKS);
  localparam int DEPTH = 2 * BUF_WORDS;
  localparam int IW    = $clog2(DEPTH);
  localparam int FW    = $clog2(DEPTH + 1);
  localparam int CW    = $clog2(PROG_LAT + DEPTH + ERASE_LAT + 1);

  cmd_t       cmd;
  seq_state_t state;
  op_kind_t   op;
  logic [CW-1:0]   cnt;
  logic            rmode_status, err, lkerr, buf_byte;
  logic [FW-1:0]   buf_n, drain;
  logic [BW-1:0]   buf_blk;
  logic [AW-1:0]   op_addr;
  logic [15:0]     op_data;
  logic [NUM_BLOCKS-1:0] locked;
  logic [OFFW-1:0] wb_rd_off;
  logic [15:0]     wb_rd_data, arr_rd;
  logic [FW-1:0]   wb_fill;

  fcs_cmd_decode u_dec (.code(bus_wdata[7:0]), .cmd(cmd));

  // named events for the checker
  logic [BW-1:0] bus_blk;
  logic lock_hit_bus, lock_hit_buf, n_ok, confirm;
  logic ev_start, ev_buf_go, ev_lock_fail, ev_abort, ev_clr, ev_done;
  logic susp_req, run, susp, buf_push, buf_clr, drain_en;
  logic lock_set, lock_sec, lock_clr;

  assign bus_blk      = bus_addr[AW-1:OFFW];
  assign lock_hit_bus = prot_hi && locked[bus_blk];
  assign lock_hit_buf = prot_hi && locked[buf_blk];
  assign n_ok         = count_arg(bus_wdata, byte_mode) <= count_max(byte_mode, BUF_WORDS);
  assign confirm      = (cmd == C_CONFIRM);

  assign ev_buf_go = bus_we && state == ST_BUF_CONFIRM && confirm && !lock_hit_buf;
  assign ev_start  = ev_buf_go ||
                     (bus_we && state == ST_PGM_SETUP && !lock_hit_bus) ||
                     (bus_we && state == ST_ERS_SETUP && confirm && !lock_hit_bus);
  assign ev_lock_fail = bus_we && ((state == ST_PGM_SETUP && lock_hit_bus) ||
                                   (state == ST_ERS_SETUP && confirm && lock_hit_bus) ||
                                   (state == ST_BUF_CONFIRM && confirm && lock_hit_buf));
  assign ev_abort = bus_we && ((state == ST_ERS_SETUP && !confirm) ||
                               (state == ST_BUF_COUNT && !n_ok) ||
                               (state == ST_BUF_CONFIRM && !confirm) ||
                               (state == ST_LOCK_SETUP && !(confirm || cmd == C_LOCK_ONE ||
                                                            cmd == C_LOCK_SEC)));
  assign ev_clr   = bus_we && state == ST_IDLE && cmd == C_CLEAR_STATUS;
  assign susp_req = bus_we && state == ST_BUSY && cmd == C_SUSPEND && op != OP_ERASE;
  assign run      = (state == ST_BUSY) && !susp_req;
  assign ev_done  = run && cnt == '0;
  assign susp     = (state == ST_SUSP);
  assign busy     = (state == ST_BUSY);
  assign buf_push = bus_we && state == ST_BUF_DATA;
  assign buf_clr  = bus_we && state == ST_IDLE && cmd == C_BUF;
  assign drain_en = run && op == OP_BUF && drain <= buf_n;

  assign lock_set = bus_we && state == ST_LOCK_SETUP && (cmd == C_LOCK_ONE || cmd == C_LOCK_SEC);
  assign lock_sec = (cmd == C_LOCK_SEC);
  assign lock_clr = bus_we && state == ST_LOCK_SETUP && confirm;

  fcs_wbuf #(.DEPTH(DEPTH), .OFFW(OFFW)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .push(buf_push),
    .push_off(bus_addr[OFFW-1:0]), .push_data(pgm_mask(bus_wdata, buf_byte)),
    .rd_idx(drain[IW-1:0]), .rd_off(wb_rd_off), .rd_data(wb_rd_data), .fill(wb_fill)
  );

  fcs_array #(.NB(NUM_BLOCKS), .WPB(WORDS_PER_BLOCK)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(drain_en || (ev_done && op == OP_WORD)),
    .wr_addr(op == OP_BUF ? {buf_blk, wb_rd_off} : op_addr),
    .wr_mask(op == OP_BUF ? wb_rd_data : op_data),
    .erase_en(ev_done && op == OP_ERASE), .erase_blk(op_addr[AW-1:OFFW]),
    .lock_set(lock_set), .lock_sec(lock_sec), .lock_blk(bus_blk), .lock_clr(lock_clr),
    .rd_addr(bus_addr), .rd_word(arr_rd), .locked(locked)
  );

  // sticky status flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err   <= 1'b0;
      lkerr <= 1'b0;
    end else if (ev_abort || ev_lock_fail) begin
      err <= 1'b1;
      if (ev_lock_fail) lkerr <= 1'b1;
    end else if (ev_clr) begin
      err   <= 1'b0;
      lkerr <= 1'b0;
    end
  end

  // command sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      op           <= OP_NONE;
      cnt          <= '0;
      rmode_status <= 1'b0;
      buf_n        <= '0;
      drain        <= '0;
      buf_blk      <= '0;
      buf_byte     <= 1'b0;
      op_addr      <= '0;
      op_data      <= 16'hFFFF;
    end else begin
      case (state)
        ST_IDLE: if (bus_we) begin
          case (cmd)
            C_READ_ARRAY:  rmode_status <= 1'b0;
            C_READ_STATUS: rmode_status <= 1'b1;
            C_PGM:        begin state <= ST_PGM_SETUP;  rmode_status <= 1'b1; end
            C_BUF:        begin state <= ST_BUF_COUNT;  rmode_status <= 1'b1; end
            C_ERASE:      begin state <= ST_ERS_SETUP;  rmode_status <= 1'b1; end
            C_LOCK_SETUP: begin state <= ST_LOCK_SETUP; rmode_status <= 1'b1; end
            default: ;
          endcase
        end
        ST_PGM_SETUP: if (bus_we) begin
          op_addr <= bus_addr;
          op_data <= pgm_mask(bus_wdata, byte_mode);
          if (lock_hit_bus) state <= ST_IDLE;
          else begin
            state <= ST_BUSY;
            op    <= OP_WORD;
            cnt   <= CW'(busy_cycles(OP_WORD, 0, PROG_LAT, ERASE_LAT) - 1);
          end
        end
        ST_ERS_SETUP: if (bus_we) begin
          op_addr <= bus_addr;
          if (!confirm || lock_hit_bus) state <= ST_IDLE;
          else begin
            state <= ST_BUSY;
            op    <= OP_ERASE;
            cnt   <= CW'(busy_cycles(OP_ERASE, 0, PROG_LAT, ERASE_LAT) - 1);
          end
        end
        ST_LOCK_SETUP: if (bus_we) state <= ST_IDLE;
        ST_BUF_COUNT: if (bus_we) begin
          if (!n_ok) state <= ST_IDLE;
          else begin
            buf_n    <= FW'(count_arg(bus_wdata, byte_mode));
            buf_blk  <= bus_blk;
            buf_byte <= byte_mode;
            state    <= ST_BUF_DATA;
          end
        end
        ST_BUF_DATA: if (bus_we && wb_fill == buf_n) state <= ST_BUF_CONFIRM;
        ST_BUF_CONFIRM: if (bus_we) begin
          if (!confirm || lock_hit_buf) state <= ST_IDLE;
          else begin
            state <= ST_BUSY;
            op    <= OP_BUF;
            drain <= '0;
            cnt   <= CW'(busy_cycles(OP_BUF, int'(buf_n), PROG_LAT, ERASE_LAT) - 1);
          end
        end
        ST_BUSY: begin
          if (susp_req) begin
            state        <= ST_SUSP;
            rmode_status <= 1'b1;
          end else begin
            if (drain_en) drain <= drain + 1'b1;
            if (cnt == '0) begin
              state <= ST_IDLE;
              op    <= OP_NONE;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        ST_SUSP: if (bus_we) begin
          case (cmd)
            C_CONFIRM:     begin state <= ST_BUSY; rmode_status <= 1'b1; end
            C_READ_ARRAY:  rmode_status <= 1'b0;
            C_READ_STATUS: rmode_status <= 1'b1;
            default: ;
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // read path
  logic [7:0] status;
  assign status        = {!busy, susp, 1'b0, err, 2'b00, lkerr, 1'b0};
  assign rd_drive_mask = busy ? 16'h0080 : 16'hFFFF;
  assign rd_data       = busy ? {8'h00, status & 8'h80}
                       : (rmode_status ? {8'h00, status} : arr_rd);
endmodule

// File: rtl/fcs_checks.sv
module fcs_checks #(
  parameter int FW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic          busy,
  input logic [15:0]   rd_data,
  input logic [15:0]   rd_drive_mask,
  input logic          ev_start,
  input logic          ev_buf_go,
  input logic          ev_abort,
  input logic          ev_lock_fail,
  input logic          ev_clr,
  input logic          err,
  input logic          susp,
  input logic [FW-1:0] wb_fill,
  input logic [FW-1:0] buf_n
);
  a_r7_busy_floats: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_drive_mask == 16'h0080 && rd_data == 16'h0000));

  a_r6_start_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> bus_we);

  a_r6_busy_rises_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !susp && !ev_start) |=> !busy);

  a_r3_full_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buf_go |-> ({1'b0, wb_fill} == {1'b0, buf_n} + 1'b1));

  a_r5_abort_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (!busy && err));

  a_r9_lock_fail_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock_fail |=> (!busy && err));

  a_r12_sticky_error: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !ev_clr) |=> err);

  a_r8_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> !busy);
endmodule

bind flash_cmd_seq fcs_checks #(.FW(FW)) u_fcs_checks (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .busy(busy),
  .rd_data(rd_data), .rd_drive_mask(rd_drive_mask),
  .ev_start(ev_start), .ev_buf_go(ev_buf_go), .ev_abort(ev_abort),
  .ev_lock_fail(ev_lock_fail), .ev_clr(ev_clr), .err(err), .susp(susp),
  .wb_fill(wb_fill), .buf_n(buf_n)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int PL = 4;
  localparam int EL = 8;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, byte_mode = 1'b0, prot_hi = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, rd_data, rd_drive_mask;
  logic busy;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_cmd_seq #(.NUM_BLOCKS(4), .WORDS_PER_BLOCK(8), .BUF_WORDS(16),
                  .PROG_LAT(PL), .ERASE_LAT(EL)) i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .byte_mode(byte_mode), .prot_hi(prot_hi),
    .rd_data(rd_data), .rd_drive_mask(rd_drive_mask), .busy(busy));

  // kind[38:37] 0=write 1=read-check 2=wait idle, addr[36:32], data[31:16], expect[15:0]
  localparam logic [38:0] VEC [16] = '{
    {2'd0, 5'd0, 16'h00FF, 16'h0000},
    {2'd1, 5'd3, 16'h0000, 16'hFFFF},
    {2'd0, 5'd3, 16'h0040, 16'h0000},
    {2'd0, 5'd3, 16'h1234, 16'h0000},
    {2'd2, 5'd0, 16'h0000, 16'h0000},
    {2'd0, 5'd0, 16'h00FF, 16'h0000},
    {2'd1, 5'd3, 16'h0000, 16'h1234},
    {2'd0, 5'd5, 16'h0010, 16'h0000},
    {2'd0, 5'd5, 16'h0F0F, 16'h0000},
    {2'd2, 5'd0, 16'h0000, 16'h0000},
    {2'd0, 5'd0, 16'h00FF, 16'h0000},
    {2'd1, 5'd5, 16'h0000, 16'h0F0F},
    {2'd0, 5'd0, 16'hAB33, 16'h0000},
    {2'd1, 5'd5, 16'h0000, 16'h0F0F},
    {2'd0, 5'd0, 16'h1270, 16'h0000},
    {2'd1, 5'd0, 16'h0000, 16'h0080}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int n;
    logic [15:0] exp_w [8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", {15'd0, busy}, 16'h0000);
    chk("R1 mask", rd_drive_mask, 16'hFFFF);
    rd("R1 array", 5'd7, 16'hFFFF);
    rd("R1 array", 5'd31, 16'hFFFF);

    // table: R2 (40h and 10h), R10 upper byte ignored, R13 undefined code
    for (int i = 0; i < 16; i++) begin
      case (VEC[i][38:37])
        2'd0: wr(VEC[i][36:32], VEC[i][31:16]);
        2'd1: rd($sformatf("R2/R10/R13 vec%0d", i), VEC[i][36:32], VEC[i][15:0]);
        default: wait_idle(n);
      endcase
    end
    chk("R13 no busy", {15'd0, busy}, 16'h0000);

    // R2 latency and R7 floating bus
    wr(5'd2, 16'h0040);
    wr(5'd2, 16'h00F0);
    chk("R7 mask", rd_drive_mask, 16'h0080);
    rd("R7 data", 5'd2, 16'h0000);
    wait_idle(n);
    chk("R2 busy cycles", 16'(n), 16'(PL));
    wr(5'd0, 16'h00FF);
    rd("R2 value", 5'd2, 16'h00F0);

    // R3 word-mode buffer, R6 no start before confirm
    wr(5'd8, 16'h00E8);
    wr(5'd8, 16'h0002);
    wr(5'd1, 16'h00AA);
    wr(5'd2, 16'h00BB);
    wr(5'd3, 16'h00CC);
    chk("R6 no busy before confirm", {15'd0, busy}, 16'h0000);
    wr(5'd8, 16'h00D0);
    wait_idle(n);
    chk("R3 busy cycles", 16'(n), 16'(PL + 3));
    wr(5'd0, 16'h00FF);
    rd("R3 word 9", 5'd9, 16'h00AA);
    rd("R3 word 10", 5'd10, 16'h00BB);
    rd("R3 word 11", 5'd11, 16'h00CC);

    // R5 abort at confirm slot, R12 sticky
    wr(5'd16, 16'h00E8);
    wr(5'd16, 16'h0001);
    wr(5'd0, 16'h0000);
    wr(5'd1, 16'h0000);
    wr(5'd16, 16'h0070);
    chk("R5 no busy", {15'd0, busy}, 16'h0000);
    rd("R5 status", 5'd0, 16'h0090);
    wr(5'd0, 16'h00FF);
    rd("R5 array", 5'd16, 16'hFFFF);
    wr(5'd4, 16'h0040);
    wr(5'd4, 16'h7777);
    wait_idle(n);
    rd("R12 sticky", 5'd0, 16'h0090);
    wr(5'd0, 16'h0050);
    rd("R12 cleared", 5'd0, 16'h0080);

    // R4 word mode over limit
    wr(5'd16, 16'h00E8);
    wr(5'd16, 16'h0010);
    rd("R4 word limit", 5'd0, 16'h0090);
    wr(5'd0, 16'h0050);

    // R4 byte mode full depth n=1Fh into block 3
    byte_mode = 1'b1;
    for (int o = 0; o < 8; o++) exp_w[o] = 16'hFFFF;
    wr(5'd24, 16'h00E8);
    wr(5'd24, 16'hAA1F);
    for (int i = 0; i < 32; i++) begin
      logic [15:0] d;
      d = 16'h0000 | 16'(8'hFF ^ (8'h01 << (i / 4)));
      exp_w[i % 8] = exp_w[i % 8] & {8'hFF, d[7:0]};
      wr(5'(i % 8), d);
    end
    chk("R6 no busy byte buffer", {15'd0, busy}, 16'h0000);
    wr(5'd24, 16'h00D0);
    wait_idle(n);
    chk("R4 byte busy cycles", 16'(n), 16'(PL + 32));
    wr(5'd0, 16'h00FF);
    for (int o = 0; o < 8; o++) rd($sformatf("R4 byte word %0d", o), 5'(24 + o), exp_w[o]);
    wr(5'd24, 16'h00E8);
    wr(5'd24, 16'h0020);
    rd("R4 byte limit", 5'd0, 16'h0090);
    wr(5'd0, 16'h0050);
    byte_mode = 1'b0;

    // R8 suspend / resume
    wr(5'd1, 16'h0040);
    wr(5'd1, 16'h5A5A);
    wr(5'd0, 16'h00B0);
    chk("R8 busy drops", {15'd0, busy}, 16'h0000);
    rd("R8 status", 5'd0, 16'h00C0);
    wr(5'd0, 16'h00FF);
    rd("R8 not written", 5'd1, 16'hFFFF);
    wr(5'd0, 16'h00D0);
    chk("R8 resumed", {15'd0, busy}, 16'h0001);
    wait_idle(n);
    wr(5'd0, 16'h00FF);
    rd("R8 completed", 5'd1, 16'h5A5A);

    // R9 / R11 locks
    wr(5'd16, 16'h0060);
    wr(5'd16, 16'h0001);
    wr(5'd17, 16'h0040);
    wr(5'd17, 16'h0000);
    chk("R9 no busy", {15'd0, busy}, 16'h0000);
    rd("R9 status", 5'd0, 16'h0092);
    wr(5'd0, 16'h00FF);
    rd("R9 unchanged", 5'd17, 16'hFFFF);
    wr(5'd0, 16'h0050);
    prot_hi = 1'b0;
    wr(5'd18, 16'h0040);
    wr(5'd18, 16'h1111);
    wait_idle(n);
    wr(5'd0, 16'h00FF);
    rd("R9 bypass", 5'd18, 16'h1111);
    prot_hi = 1'b1;
    wr(5'd24, 16'h0060);
    wr(5'd24, 16'h002F);
    wr(5'd0, 16'h0060);
    wr(5'd0, 16'h00D0);
    wr(5'd19, 16'h0040);
    wr(5'd19, 16'h2222);
    wait_idle(n);
    wr(5'd0, 16'h00FF);
    rd("R11 cleared lock", 5'd19, 16'h2222);
    wr(5'd25, 16'h0040);
    wr(5'd25, 16'h0000);
    rd("R11 security kept", 5'd0, 16'h0092);
    wr(5'd0, 16'h0050);

    // R14 erase, R8 suspend ignored in erase
    wr(5'd0, 16'h0020);
    wr(5'd0, 16'h00D0);
    wr(5'd0, 16'h00B0);
    chk("R8 erase not suspended", {15'd0, busy}, 16'h0001);
    wait_idle(n);
    chk("R14 busy cycles", 16'(n + 1), 16'(EL));
    wr(5'd0, 16'h00FF);
    rd("R14 erased 2", 5'd2, 16'hFFFF);
    rd("R14 erased 3", 5'd3, 16'hFFFF);
    rd("R14 other block", 5'd9, 16'h00AA);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule